// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, cycle by cycle, which of several hardware threads gets the single issue slot of a shared pipeline. It also keeps one program counter per thread. Each thread reports two conditions. The first says whether it can issue now. The second says whether it is blocked by a long-latency event, such as a miss that goes out to a far memory level. The block combines these with its own pointer state and presents the chosen thread, that thread's program counter and an issue-valid flag, all in the same cycle.

A mode input picks one of two switching policies. In interleaved mode the slot rotates to a different thread on every cycle and passes over any thread that cannot issue. In blocked mode one thread keeps the slot until it reports a long-latency block. Only then does the block move to another thread, and it pays a one-cycle refill bubble to do so. Short hiccups in the current thread just leave the slot empty.

The issued thread's program counter steps forward by one instruction word. A redirect port can overwrite any thread's program counter. Fetch, register storage and the pipeline that consumes the issue slot sit outside this block.

Top module: `thr_issue_sel`

## Requirements
- R1: While reset is held, thread i's program counter becomes PC_BASE + i*PC_STEP and the rotation pointer becomes thread 0. As a result, the first interleaved-mode pick with every thread eligible is thread 1.
- R2: A thread is eligible when its ready bit is 1 and its long-stall bit is 0. issue_valid is 1 only for an eligible thread. If no thread qualifies, issue_valid is 0.
- R3: In interleaved mode (sw_coarse=0), the block issues the first eligible thread found by scanning upward from the last issued thread plus one, wrapping modulo NTHREADS. The last issued thread is considered only after all the others.
- R4: In interleaved mode, ineligible threads are skipped in the same cycle and the remaining eligible threads keep issuing without a gap.
- R5: In blocked mode (sw_coarse=1), the current thread issues on every cycle in which it is eligible. A cycle with ready=0 and long-stall=0 on the current thread issues nothing and does not change the current thread.
- R6: In blocked mode, when the current thread has long-stall=1, the block picks the first eligible other thread in wrapped upward order from the current one. Nothing issues in that cycle or in the following bubble cycle, and the new thread issues from the cycle after the bubble. If no other thread is eligible, the current thread is kept and nothing issues.
- R7: At each clock edge where issue_valid=1, the issued thread's program counter increases by 4.
- R8: When redir_en=1, thread redir_tid's program counter is loaded with redir_pc at the next edge. This load overrides the increment by 4 for the same thread.
- R9: issue_pc equals the current program counter of the thread shown on issue_tid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_coarse | input | 1 | 0 = interleaved switching, 1 = blocked switching |
| thr_ready | input | NTHREADS | Per-thread can-issue flag |
| thr_long_stall | input | NTHREADS | Per-thread long-latency block flag |
| redir_en | input | 1 | Load a program counter this cycle |
| redir_tid | input | TID_W | Thread whose program counter is loaded |
| redir_pc | input | PC_W | Value loaded on a redirect |
| issue_valid | output | 1 | The slot is used this cycle |
| issue_tid | output | TID_W | Selected thread |
| issue_pc | output | PC_W | Program counter of the selected thread |

## Verification
The bench goes after the wrap of the rotation pointer. A design that scanned from zero instead of from the last issued thread would favour low-numbered threads and break the interleave order. It also drives a redirect aimed at the very thread being issued: if the increment won, that thread would continue at the old address plus 4. In blocked mode it separates short stalls from long ones and counts the cycles of a switch, so a design that switched on a short stall, or that issued during the bubble, would show the wrong thread or a premature valid. Finally it blocks every other thread during a long stall. A design that switched anyway would land on an ineligible thread.

// File: rtl/thrsel_pkg.sv
`timescale 1ns/1ps
package thrsel_pkg;
   typedef enum logic {
      SW_FINE   = 1'b0,
      SW_COARSE = 1'b1
   } sw_mode_e;
endpackage

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
// Wrapped upward search for the first set request after a base index.
module rr_pick #(
   parameter int N  = 4,
   parameter int TW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [TW-1:0] base,
   input  logic          skip_base,
   output logic          found,
   output logic [TW-1:0] idx
);
   int t;
   always_comb begin
      found = 1'b0;
      idx   = base;
      t     = 0;
      for (int k = 1; k <= N; k++) begin
         t = int'(base) + k;
         if (t >= N) t = t - N;
         if (!found && req[t[TW-1:0]] && !(k == N && skip_base)) begin
            found = 1'b1;
            idx   = t[TW-1:0];
         end
      end
   end
endmodule

// File: rtl/pc_bank.sv
`timescale 1ns/1ps
// One program counter per thread; a load beats the step.
module pc_bank #(
   parameter int          N       = 4,
   parameter int          TW      = 2,
   parameter int          PC_W    = 32,
   parameter logic [31:0] PC_BASE = 32'h0000_1000,
   parameter logic [31:0] PC_STEP = 32'h0000_0100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inc_en,
   input  logic [TW-1:0]          inc_tid,
   input  logic                   ld_en,
   input  logic [TW-1:0]          ld_tid,
   input  logic [PC_W-1:0]        ld_pc,
   output logic [N-1:0][PC_W-1:0] pcs
);
   localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

   for (genvar i = 0; i < N; i++) begin : g_pc
      logic [PC_W-1:0] pc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pc_q <= PC_W'(PC_BASE) + PC_W'(PC_STEP) * PC_W'(i);
         else if (ld_en && ld_tid == TW'(i))
            pc_q <= ld_pc;
         else if (inc_en && inc_tid == TW'(i))
            pc_q <= pc_q + INSN_BYTES;
      end
      assign pcs[i] = pc_q;
   end

   // R7: an issued thread without a competing load steps by one word
   p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !(ld_en && ld_tid == inc_tid)) |=>
         pcs[$past(inc_tid)] == $past(pcs[inc_tid]) + INSN_BYTES);

   // R8: a redirect lands regardless of a same-thread issue
   p_redir_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> pcs[$past(ld_tid)] == $past(ld_pc));
endmodule

// File: rtl/thrsel_policy.sv
`timescale 1ns/1ps
// Switching policy: interleaved or blocked, with shared pointer state.
module thrsel_policy
   import thrsel_pkg::*;
#(
   parameter int N  = 4,
   parameter int TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sw_mode_e      mode,
   input  logic [N-1:0]  ready,
   input  logic [N-1:0]  lstall,
   output logic          issue_v,
   output logic [TW-1:0] issue_tid
);
   logic [N-1:0]  elig;
   logic [TW-1:0] cur_q, cur_d;
   logic          bub_q, bub_d;
   logic          pk_found;
   logic [TW-1:0] pk_idx;

   assign elig = ready & ~lstall;

   rr_pick #(.N(N), .TW(TW)) u_pick (
      .req       (elig),
      .base      (cur_q),
      .skip_base (mode == SW_COARSE),
      .found     (pk_found),
      .idx       (pk_idx)
   );

   always_comb begin
      cur_d     = cur_q;
      bub_d     = 1'b0;
      issue_v   = 1'b0;
      issue_tid = cur_q;
      if (mode == SW_FINE) begin
         if (pk_found) begin
            issue_v   = 1'b1;
            issue_tid = pk_idx;
            cur_d     = pk_idx;
         end
      end else if (bub_q) begin
         issue_v = 1'b0;
      end else if (lstall[cur_q]) begin
         if (pk_found) begin
            cur_d = pk_idx;
            bub_d = 1'b1;
         end
      end else if (ready[cur_q]) begin
         issue_v = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         bub_q <= 1'b0;
      end else begin
         cur_q <= cur_d;
         bub_q <= bub_d;
      end
   end
endmodule

// File: rtl/thr_issue_sel.sv
`timescale 1ns/1ps
module thr_issue_sel
   import thrsel_pkg::*;
#(
   parameter int          NTHREADS = 4,
   parameter int          PC_W     = 32,
   parameter logic [31:0] PC_BASE  = 32'h0000_1000,
   parameter logic [31:0] PC_STEP  = 32'h0000_0100,
   localparam int         TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sw_coarse,
   input  logic [NTHREADS-1:0] thr_ready,
   input  logic [NTHREADS-1:0] thr_long_stall,
   input  logic                redir_en,
   input  logic [TID_W-1:0]    redir_tid,
   input  logic [PC_W-1:0]     redir_pc,
   output logic                issue_valid,
   output logic [TID_W-1:0]    issue_tid,
   output logic [PC_W-1:0]     issue_pc
);
   if (NTHREADS < 2) begin : g_bad_threads
      $error("thr_issue_sel: NTHREADS must be at least 2");
   end
   if (PC_W < 8 || PC_W > 32) begin : g_bad_pcw
      $error("thr_issue_sel: PC_W must lie in 8..32");
   end
   if (PC_BASE[1:0] != 2'b00 || PC_STEP[1:0] != 2'b00) begin : g_bad_align
      $error("thr_issue_sel: reset PCs must be word aligned");
   end

   logic [NTHREADS-1:0][PC_W-1:0] pcs;
   logic [NTHREADS-1:0]           elig;
   sw_mode_e                      mode;
   logic                          arm_q;

   assign mode = sw_coarse ? SW_COARSE : SW_FINE;
   assign elig = thr_ready & ~thr_long_stall;

   thrsel_policy #(.N(NTHREADS), .TW(TID_W)) u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .ready     (thr_ready),
      .lstall    (thr_long_stall),
      .issue_v   (issue_valid),
      .issue_tid (issue_tid)
   );

   pc_bank #(
      .N(NTHREADS), .TW(TID_W), .PC_W(PC_W),
      .PC_BASE(PC_BASE), .PC_STEP(PC_STEP)
   ) u_pcs (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (issue_valid),
      .inc_tid (issue_tid),
      .ld_en   (redir_en),
      .ld_tid  (redir_tid),
      .ld_pc   (redir_pc),
      .pcs     (pcs)
   );

   assign issue_pc = pcs[issue_tid];

   always_ff @(posedge clk) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= 1'b1;
   end

   // R2: the slot only goes to a thread that can issue
   p_elig_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> elig[issue_tid]);

   // R3: with a second eligible thread, interleaved mode never repeats
   p_fine_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && issue_valid && !sw_coarse && $past(issue_valid && !sw_coarse)
       && $countones(elig) > 1) |-> issue_tid != $past(issue_tid));

   // R5: blocked mode never changes thread between back-to-back issues
   p_coarse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && issue_valid && sw_coarse && $past(issue_valid && sw_coarse))
         |-> issue_tid == $past(issue_tid));
endmodule

// File: tb/sim_thr_issue_sel.sv
`timescale 1ns/1ps
module sim_thr_issue_sel;
   localparam int          T    = 4;
   localparam int          PCW  = 32;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [31:0] STEP = 32'h0000_0100;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           sw_coarse;
   logic [T-1:0]   thr_ready, thr_long_stall;
   logic           redir_en;
   logic [1:0]     redir_tid;
   logic [PCW-1:0] redir_pc;
   logic           issue_valid;
   logic [1:0]     issue_tid;
   logic [PCW-1:0] issue_pc;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 0;

   // reference state
   int unsigned mpc [T];
   int          mcur;
   bit          mbub;

   always #2 clk = ~clk;

   thr_issue_sel #(.NTHREADS(T), .PC_W(PCW), .PC_BASE(BASE), .PC_STEP(STEP)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_coarse(sw_coarse),
      .thr_ready(thr_ready), .thr_long_stall(thr_long_stall),
      .redir_en(redir_en), .redir_tid(redir_tid), .redir_pc(redir_pc),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic bit can_go(input int i);
      return thr_ready[i] && !thr_long_stall[i];
   endfunction

   // decision of the reference; returns next pointer/bubble by ref
   task automatic decide(output bit v, output int sel, output int ncur, output bit nbub);
      v = 0; sel = mcur; ncur = mcur; nbub = 0;
      if (!sw_coarse) begin
         for (int k = 1; k <= T; k++) begin
            int c = (mcur + k) % T;
            if (!v && can_go(c)) begin v = 1; sel = c; ncur = c; end
         end
      end else if (mbub) begin
         v = 0;
      end else if (thr_long_stall[mcur]) begin
         for (int k = 1; k < T; k++) begin
            int c = (mcur + k) % T;
            if (!nbub && can_go(c)) begin nbub = 1; ncur = c; end
         end
      end else if (thr_ready[mcur]) begin
         v = 1;
      end
   endtask

   // inputs already applied just after a falling edge
   task automatic cyc(input string tag);
      bit v, nb; int s, nc;
      #1;
      decide(v, s, nc, nb);
      chk({tag, " valid R2"}, 32'(issue_valid), 32'(v));
      if (v) begin
         chk({tag, " tid"}, 32'(issue_tid), 32'(s));
         chk({tag, " pc R7/R9"}, issue_pc, mpc[s]);
      end
      @(posedge clk);
      if (v) mpc[s] = mpc[s] + 4;
      if (redir_en) mpc[redir_tid] = redir_pc;
      mcur = nc;
      mbub = nb;
      @(negedge clk);
   endtask

   task automatic model_reset();
      for (int i = 0; i < T; i++) mpc[i] = BASE + STEP * i;
      mcur = 0;
      mbub = 0;
   endtask

   initial begin
      rst_n = 0; sw_coarse = 0; thr_ready = '0; thr_long_stall = '0;
      redir_en = 0; redir_tid = '0; redir_pc = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state seen through the first interleaved pick
      thr_ready = 4'hF;
      #1;
      chk("R1 first tid", 32'(issue_tid), 32'd1);
      chk("R1 first pc", issue_pc, BASE + STEP);
      chk("R1 first valid", 32'(issue_valid), 32'd1);
      #1; @(negedge clk);
      model_reset();
      // re-align: the pick above was not yet clocked when the model reset
      // (it was sampled before the edge), so replay the clocked effect
      mpc[1] = mpc[1] + 4; mcur = 1;

      // R3: full rotation with wrap
      repeat (9) cyc("R3");

      // R4: skip stalled threads
      thr_long_stall = 4'b0100; repeat (6) cyc("R4");
      thr_long_stall = 4'b0000; thr_ready = 4'b1010; repeat (5) cyc("R4");
      thr_ready = 4'b0001; repeat (3) cyc("R4");

      // R2: nothing eligible
      thr_ready = 4'b0000; repeat (3) cyc("R2");
      thr_ready = 4'b0010; thr_long_stall = 4'b0010; repeat (2) cyc("R2");
      thr_long_stall = 4'b0000; thr_ready = 4'hF;

      // R8: redirect the thread issuing this very cycle
      redir_en = 1; redir_tid = 2'((mcur + 1) % T); redir_pc = 32'h0000_8000;
      cyc("R8");
      redir_tid = 2'((mcur + 2) % T); redir_pc = 32'h0000_9000;
      cyc("R8");
      redir_en = 0;
      repeat (6) cyc("R8");

      // R5: blocked mode holds the thread, short stall idles
      sw_coarse = 1;
      repeat (5) cyc("R5");
      thr_ready = 4'hF & ~(4'b1 << mcur); repeat (3) cyc("R5");
      thr_ready = 4'hF; repeat (2) cyc("R5");

      // R6: long stall forces a switch with a bubble
      thr_long_stall = 4'b1 << mcur;
      repeat (4) cyc("R6");
      thr_long_stall = 4'b0; repeat (3) cyc("R6");
      // no other thread available: stay, issue nothing
      thr_ready = 4'b1 << mcur; thr_long_stall = 4'b1 << mcur;
      repeat (3) cyc("R6");
      thr_long_stall = 4'b0; repeat (2) cyc("R6");
      thr_ready = 4'hF;

      // mixed traffic across both modes
      for (int n = 0; n < 600; n++) begin
         if (n % 60 == 0) sw_coarse = ~sw_coarse;
         thr_ready      = 4'($urandom() % 16);
         thr_long_stall = 4'(($urandom() % 16) & ($urandom() % 16));
         redir_en       = ($urandom() % 8) == 0;
         redir_tid      = 2'($urandom() % T);
         redir_pc       = {16'h0, 14'($urandom()), 2'b00};
         cyc("R7");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule